// File: doc/BRIEF.md
# Two-Tier Prioritized Interrupt Controller

This block collects single-cycle event pulses from many on-chip sources into a group of 32-bit register sets and turns them into two CPU interrupt request lines. A fixed subset of sources belongs to a high class: each of them has a priority level from 1 to 15. The controller reports the numerically highest pending level that is enabled as a 4-bit vector, and it drives the urgent request line from it. Every other source belongs to the low class. A low-class source is gated by its own enable bit and drives a second, separate request line.

Software reaches the block through a synchronous word-addressed read/write port. Every source set has a sticky status register, a write-one-to-clear register and an enable register. Set 0 is a summary set. Its status word carries the two path flags and the vector. Its enable word carries the global enable and a mask with one bit per level. Status bits keep recording events while the outputs are gated off. Software can therefore poll the pending sources and acknowledge them without taking an interrupt.

Top module: `icu_two_tier`

## Requirements
- R1: The word address is set index times 4 plus a kind code: 0 status, 1 clear, 2 enable, 3 reserved. Set 0 is the summary set and sets 1..NSETS hold sources. Source line L = set*32 + bit is driven on `src_i[L-32]`, so no line exists below 32.
- R2: A pulse on a source sets its status bit. The bit stays set until a clear-register write has a 1 in that position. If a pulse and a clear of the same bit happen in the same cycle, the bit stays set.
- R3: A read of any clear register, of a reserved kind, or of a set index above NSETS returns 0. A write to a reserved kind or to a nonexistent set changes no state.
- R4: The high-class levels are fixed as follows. Set 5 bits 24 and 25 (power-good falling and rising) are level 15. Set 5 bit 30 (alarm) is 14 and set 5 bit 29 (periodic tick) is 13. Set 2 bits 31 and 21 are 11 and 10. Set 1 bits 18, 17 and 27 are 4, 3 and 2. Set 5 bits 7 and 0 are level 1. All other bits are low class.
- R5: The summary status word has the high flag in bit 31, the low flag in bit 30 and the vector in bits 3:0. The vector is the highest level that has a pending source and whose mask bit is set, or 0 when no such level exists. The high flag is set exactly when the vector is nonzero.
- R6: In the summary enable word, bit 0 is the global enable and bit L (1..15) unmasks level L. When all mask bits are 0, the high request line stays low whatever sources are pending.
- R7: The low flag is set when a low-class bit is pending and its enable bit is set in the same set. Enable bits of high-class sources have no effect on the low path.
- R8: `irq_hi_o` and `irq_lo_o` are registered: each equals the global enable AND the high or low flag of the previous cycle. Both are 0 after reset.
- R9: With the global enable at 0, both request lines stay low. Status bits and summary flags keep updating.
- R10: `rdata` takes the addressed word one cycle after a cycle with `rd_en` high and holds it until the next read.
- R11: An edge-sensing input reports each direction in its own bit. Rising edges of inputs 0 and 1 are set 3 bits 0 and 1 at level 8. Falling edges are set 4 bits 0 and 1 at level 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NSETS*32 | One-cycle event pulses, bit L-32 for line L |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | clog2(NSETS+1)+2 | Word address: set index and kind code |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_hi_o | output | 1 | Urgent (prioritized) CPU request line |
| irq_lo_o | output | 1 | Ordinary (flat-enable) CPU request line |

## Verification
The assertions check four things on every cycle. The vector only ever names an unmasked level. A zero global enable silences both lines on the next cycle, and a nonzero vector with the global enable set raises the urgent line. Status bits are never lost without a clear write, and clear registers read as zero. What is left depends on particular values and needs the bench's scenarios and its reference model. That covers the contents of the level table, and winner selection as pending levels are cleared one by one. It also covers the same-cycle pulse-and-clear race, the proof that high-class enable bits leave the low line untouched, and the way invalid addresses read and ignore writes.

// File: rtl/icu_pkg.sv
package icu_pkg;

  localparam int SET_W   = 32;
  localparam int LVL_W   = 4;
  localparam int NUM_LVL = 16;

  typedef enum logic [1:0] {
    K_STAT = 2'd0,
    K_CLR  = 2'd1,
    K_EN   = 2'd2,
    K_RSV  = 2'd3
  } reg_kind_e;

  // Fixed priority level of a source; 0 means low class.
  function automatic logic [LVL_W-1:0] hi_level(input int set_idx, input int bit_idx);
    case (set_idx * SET_W + bit_idx)
      185, 184: return 4'd15;
      190:      return 4'd14;
      189:      return 4'd13;
      95:       return 4'd11;
      85:       return 4'd10;
      96, 97:   return 4'd8;
      128, 129: return 4'd6;
      50:       return 4'd4;
      49:       return 4'd3;
      59:       return 4'd2;
      167, 160: return 4'd1;
      default:  return 4'd0;
    endcase
  endfunction

  function automatic logic [SET_W-1:0] hi_bits(input int set_idx);
    logic [SET_W-1:0] r;
    r = '0;
    for (int b = 0; b < SET_W; b++) r[b] = (hi_level(set_idx, b) != '0);
    return r;
  endfunction

endpackage

// File: rtl/icu_regset.sv
module icu_regset
  import icu_pkg::*;
#(
  parameter int IDX = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] pulse_i,
  input  logic             clr_we_i,
  input  logic             en_we_i,
  input  logic [SET_W-1:0] wdata_i,
  output logic [SET_W-1:0] stat_o,
  output logic [SET_W-1:0] en_o,
  output logic             lo_req_o
);

  localparam logic [SET_W-1:0] HI_BITS = hi_bits(IDX);

  logic [SET_W-1:0] stat_q, en_q, clr_mask;

  assign clr_mask = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_mask) | pulse_i;
      if (en_we_i) en_q <= wdata_i;
    end
  end

  assign stat_o   = stat_q;
  assign en_o     = en_q;
  assign lo_req_o = |(stat_q & en_q & ~HI_BITS);

endmodule

// File: rtl/icu_prio_enc.sv
module icu_prio_enc
  import icu_pkg::*;
#(
  parameter int NSETS = 5
) (
  input  logic [NSETS*SET_W-1:0] stat_i,
  input  logic [NUM_LVL-1:1]     mask_i,
  output logic [LVL_W-1:0]       vec_o
);

  logic [NUM_LVL-1:1] lvl_pend;

  always_comb begin
    lvl_pend = '0;
    for (int s = 0; s < NSETS; s++) begin
      for (int b = 0; b < SET_W; b++) begin
        if (hi_level(s + 1, b) != '0)
          lvl_pend[hi_level(s + 1, b)] = lvl_pend[hi_level(s + 1, b)] | stat_i[s*SET_W + b];
      end
    end
  end

  always_comb begin
    vec_o = '0;
    for (int l = 1; l < NUM_LVL; l++) begin
      if (lvl_pend[l] && mask_i[l]) vec_o = LVL_W'(l);
    end
  end

endmodule

// File: rtl/icu_two_tier.sv
module icu_two_tier
  import icu_pkg::*;
#(
  parameter  int NSETS  = 5,
  localparam int SET_AW = $clog2(NSETS + 1),
  localparam int AW     = SET_AW + 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NSETS*SET_W-1:0] src_i,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [AW-1:0]          addr,
  input  logic [SET_W-1:0]       wdata,
  output logic [SET_W-1:0]       rdata,
  output logic                   irq_hi_o,
  output logic                   irq_lo_o
);

  logic [SET_AW-1:0]      sel;
  logic [1:0]             kind;
  logic [NSETS*SET_W-1:0] stat_all, en_all;
  logic [NSETS-1:0]       lo_req;
  logic [NUM_LVL-1:0]     sum_en_q;
  logic [LVL_W-1:0]       hi_vec;
  logic                   hi_flag, lo_flag;
  logic [SET_W-1:0]       rd_val;

  assign {sel, kind} = addr;

  for (genvar g = 1; g <= NSETS; g++) begin : g_set
    localparam logic [SET_AW-1:0] GI = SET_AW'(g);
    logic clr_we, en_we;
    assign clr_we = wr_en && (sel == GI) && (kind == K_CLR);
    assign en_we  = wr_en && (sel == GI) && (kind == K_EN);

    icu_regset #(.IDX(g)) u_set (
      .clk     (clk),
      .rst     (rst),
      .pulse_i (src_i[(g-1)*SET_W +: SET_W]),
      .clr_we_i(clr_we),
      .en_we_i (en_we),
      .wdata_i (wdata),
      .stat_o  (stat_all[(g-1)*SET_W +: SET_W]),
      .en_o    (en_all[(g-1)*SET_W +: SET_W]),
      .lo_req_o(lo_req[g-1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) sum_en_q <= '0;
    else if (wr_en && (sel == '0) && (kind == K_EN)) sum_en_q <= wdata[NUM_LVL-1:0];
  end

  icu_prio_enc #(.NSETS(NSETS)) u_enc (
    .stat_i(stat_all),
    .mask_i(sum_en_q[NUM_LVL-1:1]),
    .vec_o (hi_vec)
  );

  assign hi_flag = (hi_vec != '0);
  assign lo_flag = |lo_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_hi_o <= 1'b0;
      irq_lo_o <= 1'b0;
    end else begin
      irq_hi_o <= sum_en_q[0] && hi_flag;
      irq_lo_o <= sum_en_q[0] && lo_flag;
    end
  end

  always_comb begin
    rd_val = '0;
    if (sel == '0) begin
      case (kind)
        K_STAT:  rd_val = {hi_flag, lo_flag, {(SET_W-2-LVL_W){1'b0}}, hi_vec};
        K_EN:    rd_val = {{(SET_W-NUM_LVL){1'b0}}, sum_en_q};
        default: rd_val = '0;
      endcase
    end else begin
      for (int s = 0; s < NSETS; s++) begin
        if (sel == SET_AW'(s + 1)) begin
          case (kind)
            K_STAT:  rd_val = stat_all[s*SET_W +: SET_W];
            K_EN:    rd_val = en_all[s*SET_W +: SET_W];
            default: rd_val = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end

endmodule

// File: rtl/icu_two_tier_chk.sv
module icu_two_tier_chk
  import icu_pkg::*;
#(
  parameter int NSETS = 5,
  parameter int AW    = 5
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NSETS*SET_W-1:0] src_i,
  input logic                   wr_en,
  input logic                   rd_en,
  input logic [AW-1:0]          addr,
  input logic [SET_W-1:0]       rdata,
  input logic                   irq_hi_o,
  input logic                   irq_lo_o,
  input logic [NSETS*SET_W-1:0] stat_all,
  input logic [LVL_W-1:0]       vec,
  input logic [NUM_LVL-1:0]     sum_en
);

  logic clr_write;
  assign clr_write = wr_en && (addr[1:0] == K_CLR);

  assert_vec_unmasked_R5: assert property (@(posedge clk) disable iff (rst)
    (vec != '0) |-> sum_en[vec]);

  assert_gate_off_R9: assert property (@(posedge clk) disable iff (rst)
    !sum_en[0] |=> (!irq_hi_o && !irq_lo_o));

  assert_hi_raise_R8: assert property (@(posedge clk) disable iff (rst)
    ((vec != '0) && sum_en[0]) |=> irq_hi_o);

  assert_pulse_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (src_i != '0) |=> ((stat_all & $past(src_i)) == $past(src_i)));

  assert_no_loss_R2: assert property (@(posedge clk) disable iff (rst)
    !clr_write |=> ((stat_all & $past(stat_all)) == $past(stat_all)));

  assert_clr_reads_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr[1:0] == K_CLR)) |=> (rdata == '0));

endmodule

bind icu_two_tier icu_two_tier_chk #(.NSETS(NSETS), .AW(AW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .src_i   (src_i),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .rdata   (rdata),
  .irq_hi_o(irq_hi_o),
  .irq_lo_o(irq_lo_o),
  .stat_all(stat_all),
  .vec     (hi_vec),
  .sum_en  (sum_en_q)
);

// File: tb/icu_two_tier_tb.sv
`timescale 1ns/1ps
module icu_two_tier_tb;

  localparam int NS = 5;
  localparam int AW = $clog2(NS + 1) + 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NS*32-1:0] src_i = '0;
  logic            wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic            irq_hi_o, irq_lo_o;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  icu_two_tier #(.NSETS(NS)) u_dut (
    .clk(clk), .rst(rst), .src_i(src_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_hi_o(irq_hi_o), .irq_lo_o(irq_lo_o)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_stat [1:NS];
  logic [31:0] m_en   [1:NS];
  logic [15:0] m_sen;
  logic [31:0] m_rd;
  logic        m_hi, m_lo;

  function automatic int lvl(int s, int b);
    if (s == 5 && (b == 24 || b == 25)) return 15;
    if (s == 5 && b == 30) return 14;
    if (s == 5 && b == 29) return 13;
    if (s == 2 && b == 31) return 11;
    if (s == 2 && b == 21) return 10;
    if (s == 3 && b <= 1)  return 8;
    if (s == 4 && b <= 1)  return 6;
    if (s == 1 && b == 18) return 4;
    if (s == 1 && b == 17) return 3;
    if (s == 1 && b == 27) return 2;
    if (s == 5 && (b == 7 || b == 0)) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] mread(int a, int vec, bit lo);
    int s, k;
    logic [31:0] r;
    s = a / 4; k = a % 4; r = '0;
    if (s == 0) begin
      if (k == 0) begin r[31] = (vec != 0); r[30] = lo; r[3:0] = 4'(vec); end
      if (k == 2) r[15:0] = m_sen;
    end else if (s <= NS) begin
      if (k == 0) r = m_stat[s];
      if (k == 2) r = m_en[s];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    int vec, l;
    bit lo;
    logic [31:0] clr;
    if (rst) begin
      for (int s = 1; s <= NS; s++) begin m_stat[s] = '0; m_en[s] = '0; end
      m_sen = '0; m_rd = '0; m_hi = 0; m_lo = 0;
    end else begin
      vec = 0; lo = 0;
      for (int s = 1; s <= NS; s++)
        for (int b = 0; b < 32; b++)
          if (m_stat[s][b]) begin
            l = lvl(s, b);
            if (l == 0) begin if (m_en[s][b]) lo = 1; end
            else if (m_sen[l] && l > vec) vec = l;
          end
      m_hi = m_sen[0] && (vec != 0);
      m_lo = m_sen[0] && lo;
      if (rd_en) m_rd = mread(int'(addr), vec, lo);
      for (int s = 1; s <= NS; s++) begin
        clr = (wr_en && int'(addr) == s*4 + 1) ? wdata : '0;
        m_stat[s] = (m_stat[s] & ~clr) | src_i[(s-1)*32 +: 32];
        if (wr_en && int'(addr) == s*4 + 2) m_en[s] = wdata;
      end
      if (wr_en && int'(addr) == 2) m_sen = wdata[15:0];
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every cycle
  always @(negedge clk) begin
    if (!rst) begin
      chk("R8 irq_hi", {31'b0, irq_hi_o}, {31'b0, m_hi});
      chk("R7 irq_lo", {31'b0, irq_lo_o}, {31'b0, m_lo});
      chk("R10 rdata", rdata, m_rd);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [AW-1:0] A(int s, int k);
    return AW'(s*4 + k);
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(string tag, logic [AW-1:0] a, logic [31:0] exp);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
    chk(tag, rdata, exp);
  endtask

  task automatic pulse(int s, int b);
    @(negedge clk); src_i[(s-1)*32 + b] = 1'b1;
    @(negedge clk); src_i = '0;
  endtask

  initial begin
    idle(3);
    chk("R8 reset hi", {31'b0, irq_hi_o}, 32'd0);
    chk("R8 reset lo", {31'b0, irq_lo_o}, 32'd0);
    chk("R10 reset rdata", rdata, 32'd0);
    @(negedge clk); rst = 0;

    // low path
    wr(A(0,2), 32'h1);
    wr(A(1,2), 32'h8);
    rd_chk("R1 enable readback", A(1,2), 32'h8);
    pulse(1, 3); idle(1);
    chk("R7 low request", {31'b0, irq_lo_o}, 32'd1);
    rd_chk("R2 status set", A(1,0), 32'h8);
    rd_chk("R5 low flag", A(0,0), 32'h4000_0000);
    wr(A(1,1), 32'h8);
    rd_chk("R2 cleared", A(1,0), 32'h0);
    idle(1);
    chk("R7 low drops", {31'b0, irq_lo_o}, 32'd0);
    pulse(1, 5); idle(2);
    chk("R7 disabled bit", {31'b0, irq_lo_o}, 32'd0);
    rd_chk("R2 disabled bit recorded", A(1,0), 32'h20);

    // high-class enable bit has no effect; zero mask blocks high path
    wr(A(5,2), 32'h0200_0000);
    pulse(5, 25); idle(2);
    chk("R7 high bit ignores enable", {31'b0, irq_lo_o}, 32'd0);
    chk("R6 zero mask", {31'b0, irq_hi_o}, 32'd0);
    rd_chk("R6 summary masked", A(0,0), 32'h0);
    wr(A(0,2), 32'h8001); idle(1);
    chk("R8 high request", {31'b0, irq_hi_o}, 32'd1);
    rd_chk("R4 level 15", A(0,0), 32'h8000_000F);

    // ordering among levels
    wr(A(5,1), 32'h0200_0000);
    @(negedge clk); src_i[4*32 + 30] = 1; src_i[18] = 1;
    @(negedge clk); src_i = '0;
    wr(A(0,2), 32'h4011);
    rd_chk("R4 alarm level 14", A(0,0), 32'h8000_000E);
    wr(A(5,1), 32'h4000_0000);
    rd_chk("R5 next level 4", A(0,0), 32'h8000_0004);
    wr(A(1,1), 32'h0004_0000);
    rd_chk("R5 vector zero", A(0,0), 32'h0);

    // edge inputs
    wr(A(0,2), 32'h0141);
    pulse(3, 0); pulse(4, 0);
    rd_chk("R11 rising level 8", A(0,0), 32'h8000_0008);
    wr(A(3,1), 32'h1);
    rd_chk("R11 falling level 6", A(0,0), 32'h8000_0006);
    wr(A(4,1), 32'h1);
    rd_chk("R11 both cleared", A(0,0), 32'h0);

    // pulse and clear in the same cycle
    @(negedge clk); src_i[5] = 1; wr_en = 1; addr = A(1,1); wdata = 32'h20;
    @(negedge clk); src_i = '0; wr_en = 0;
    rd_chk("R2 pulse beats clear", A(1,0), 32'h20);
    wr(A(1,1), 32'h20);

    // global enable off
    wr(A(0,2), 32'h8000);
    pulse(1, 3); pulse(5, 24); idle(2);
    chk("R9 hi gated", {31'b0, irq_hi_o}, 32'd0);
    chk("R9 lo gated", {31'b0, irq_lo_o}, 32'd0);
    rd_chk("R9 status recorded", A(1,0), 32'h8);
    rd_chk("R9 flags shown", A(0,0), 32'hC000_000F);
    wr(A(0,2), 32'h8001); idle(1);
    chk("R8 hi after enable", {31'b0, irq_hi_o}, 32'd1);
    chk("R8 lo after enable", {31'b0, irq_lo_o}, 32'd1);

    // invalid and clear addresses
    rd_chk("R3 clear reads zero", A(1,1), 32'h0);
    rd_chk("R3 reserved kind", A(1,3), 32'h0);
    wr(A(6,1), 32'hFFFF_FFFF);
    wr(A(1,3), 32'hFFFF_FFFF);
    rd_chk("R3 bad writes ignored", A(1,0), 32'h8);
    rd_chk("R3 missing set", A(7,0), 32'h0);
    idle(2);
    chk("R10 rdata holds", rdata, 32'h0);

    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule